// File: doc/BRIEF.md
# SDRAM Start-Up Command Sequencer

This block brings a single data rate SDRAM from power-on to a usable state before any read or write traffic reaches it. After reset it holds the clock enable low and drives only idle cycles for a programmable power-on interval. It then raises the clock enable and issues a fixed series of commands: a precharge of all banks, two auto-refresh commands and a mode register load. When the mobile-device input is set, it also loads the extended mode register. Each command is followed by an idle gap whose length comes from a run-time input.

All intervals come from configuration inputs, so one netlist serves devices of different speed grades and clock rates. The mode and extended mode words, which include the CAS latency field, are also inputs and are copied to the address pins unchanged. When the last gap has elapsed, the ready output rises. The controller around this block may then start serving requests. The ready output stays high until the next reset. The configuration inputs are expected to be held steady from reset until ready rises.

Top module: `sdram_boot_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its power-on wait state. In the following cycle `ready` and `cke` are low and an idle command is driven.
- R2: After `rst` falls, `cke` stays low with idle commands for exactly `cfg_init_wait` cycles. Then comes one idle cycle with `cke` high, then the precharge. No refresh or mode load is issued before that precharge.
- R3: Every cycle without a command drives the idle encoding: `cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1, `addr`=0, `ba`=0. Every cycle with `cke` low is idle.
- R4: The all-bank precharge drives `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, with `addr` bit 10 set, all other `addr` bits zero and `ba`=0.
- R5: Exactly `cfg_trp` idle cycles separate the precharge from the first auto-refresh (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, `addr`=0, `ba`=0).
- R6: Two auto-refresh commands are issued. Each is followed by exactly `cfg_trfc` idle cycles before the next command.
- R7: The mode register load drives all four command strobes low, with `addr`=`cfg_mode` and `ba`=0.
- R8: With `mobile_en` high, the mode register load is followed by exactly `cfg_tmrd` idle cycles and then a second load with `addr`=`cfg_ext_mode` and `ba`=2'b10. With `mobile_en` low, no load with `ba`=2'b10 is ever issued.
- R9: `ready` rises after exactly `cfg_tmrd` idle cycles following the last mode load. From then on it stays high, with `cke` high and idle commands, until reset.
- R10: An interval input of zero places the next command in the cycle right after the previous one, with no idle cycle between them.
- R11: A reset in the middle of the sequence restarts it from the power-on wait, with the full timing applied again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mobile_en | input | 1 | Selects the mobile start-up sequence (adds extended mode load) |
| cfg_init_wait | input | CNT_W | Power-on wait length in cycles |
| cfg_trp | input | TIM_W | Idle cycles after the precharge |
| cfg_trfc | input | TIM_W | Idle cycles after each auto-refresh |
| cfg_tmrd | input | TIM_W | Idle cycles after each mode register load |
| cfg_mode | input | ADDR_W | Mode register word (burst, CAS latency) |
| cfg_ext_mode | input | ADDR_W | Extended mode register word |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins |
| ba | output | 2 | Bank address |
| ready | output | 1 | Start-up complete |

## Verification
The bound checker enforces several rules on every cycle. Reset clears `ready` and `cke`. Low `cke` always means idle. A precharge comes before any refresh or mode load, and the gap before the first refresh equals `cfg_trp`. An extended load appears only in mobile mode and only with bank address 2'b10. Once `ready` is high it stays high over idle cycles. The exact cycle position of every command, the refresh and mode gaps, the address words and the zero-interval and mid-sequence reset cases are shown only by the bench. It compares each sampled cycle of a run with a timeline computed from the configuration.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

  typedef enum logic [3:0] {
    ST_PWR   = 4'd0,
    ST_CKE   = 4'd1,
    ST_PRE   = 4'd2,
    ST_WRP   = 4'd3,
    ST_REF1  = 4'd4,
    ST_WRFC1 = 4'd5,
    ST_REF2  = 4'd6,
    ST_WRFC2 = 4'd7,
    ST_LMR   = 4'd8,
    ST_WMRD1 = 4'd9,
    ST_LEMR  = 4'd10,
    ST_WMRD2 = 4'd11,
    ST_DONE  = 4'd12
  } boot_st_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_IDLE = 4'b0111;
  localparam logic [3:0] CMD_PALL = 4'b0010;
  localparam logic [3:0] CMD_AREF = 4'b0001;
  localparam logic [3:0] CMD_LOAD = 4'b0000;

  localparam logic [1:0] BA_EXT = 2'b10;

  // Counter load for a gap of t idle cycles (the gap state lasts t cycles).
  function automatic logic [31:0] gap_load(input logic [31:0] t);
    return (t == 32'd0) ? 32'd0 : t - 32'd1;
  endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rst_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= rst_val;
    else if (load)      cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
  import sdram_boot_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TIM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mobile_en,
  input  logic [TIM_W-1:0] cfg_trp,
  input  logic [TIM_W-1:0] cfg_trfc,
  input  logic [TIM_W-1:0] cfg_tmrd,
  input  logic             tmr_zero,
  output boot_st_t         state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  boot_st_t st_q, st_d;
  logic [31:0] ld32;

  // Gap lookup for the command state being left and the state after the gap.
  logic [TIM_W-1:0] gap_t;
  boot_st_t         after_gap;
  boot_st_t         gap_st;

  always_comb begin
    gap_t     = '0;
    after_gap = ST_DONE;
    gap_st    = ST_DONE;
    case (st_q)
      ST_PRE:  begin gap_t = cfg_trp;  gap_st = ST_WRP;   after_gap = ST_REF1; end
      ST_REF1: begin gap_t = cfg_trfc; gap_st = ST_WRFC1; after_gap = ST_REF2; end
      ST_REF2: begin gap_t = cfg_trfc; gap_st = ST_WRFC2; after_gap = ST_LMR;  end
      ST_LMR:  begin gap_t = cfg_tmrd; gap_st = ST_WMRD1;
                     after_gap = mobile_en ? ST_LEMR : ST_DONE; end
      ST_LEMR: begin gap_t = cfg_tmrd; gap_st = ST_WMRD2; after_gap = ST_DONE; end
      default: ;
    endcase
  end

  assign ld32 = gap_load(32'(gap_t));

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = ld32[CNT_W-1:0];
    case (st_q)
      ST_PWR:   if (tmr_zero) st_d = ST_CKE;
      ST_CKE:   st_d = ST_PRE;
      ST_PRE, ST_REF1, ST_REF2, ST_LMR, ST_LEMR: begin
        if (gap_t == '0) st_d = after_gap;
        else begin
          st_d     = gap_st;
          tmr_load = 1'b1;
        end
      end
      ST_WRP:   if (tmr_zero) st_d = ST_REF1;
      ST_WRFC1: if (tmr_zero) st_d = ST_REF2;
      ST_WRFC2: if (tmr_zero) st_d = ST_LMR;
      ST_WMRD1: if (tmr_zero) st_d = mobile_en ? ST_LEMR : ST_DONE;
      ST_WMRD2: if (tmr_zero) st_d = ST_DONE;
      ST_DONE:  st_d = ST_DONE;
      default:  st_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_PWR;
    else     st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/sdram_boot_cmd.sv
module sdram_boot_cmd
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  boot_st_t          state,
  input  logic [ADDR_W-1:0] cfg_mode,
  input  logic [ADDR_W-1:0] cfg_ext_mode,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              ready
);
  always_comb begin
    cke   = (state != ST_PWR);
    ready = (state == ST_DONE);
    cmd   = CMD_IDLE;
    addr  = '0;
    ba    = '0;
    case (state)
      ST_PRE: begin
        cmd      = CMD_PALL;
        addr[10] = 1'b1;
      end
      ST_REF1, ST_REF2: cmd = CMD_AREF;
      ST_LMR: begin
        cmd  = CMD_LOAD;
        addr = cfg_mode;
      end
      ST_LEMR: begin
        cmd  = CMD_LOAD;
        addr = cfg_ext_mode;
        ba   = BA_EXT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
  import sdram_boot_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 16,
  parameter int TIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mobile_en,
  input  logic [CNT_W-1:0]  cfg_init_wait,
  input  logic [TIM_W-1:0]  cfg_trp,
  input  logic [TIM_W-1:0]  cfg_trfc,
  input  logic [TIM_W-1:0]  cfg_tmrd,
  input  logic [ADDR_W-1:0] cfg_mode,
  input  logic [ADDR_W-1:0] cfg_ext_mode,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              ready
);
  localparam bit WIDTHS_OK = (ADDR_W >= 11) && (TIM_W <= CNT_W);

  boot_st_t         state;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic [3:0]       cmd;

  // Named internal events for the checker
  logic ev_pre, ev_emr;
  assign ev_pre = (state == ST_PRE);
  assign ev_emr = (state == ST_LEMR);

  initial begin
    if (!WIDTHS_OK) $error("sdram_boot_seq: width parameters out of range");
  end

  sdram_boot_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .rst_val(cfg_init_wait),
    .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sdram_boot_fsm #(.CNT_W(CNT_W), .TIM_W(TIM_W)) fsm_i (
    .clk(clk), .rst(rst), .mobile_en(mobile_en),
    .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc), .cfg_tmrd(cfg_tmrd),
    .tmr_zero(tmr_zero), .state(state),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  sdram_boot_cmd #(.ADDR_W(ADDR_W)) cmd_i (
    .state(state), .cfg_mode(cfg_mode), .cfg_ext_mode(cfg_ext_mode),
    .cke(cke), .cmd(cmd), .addr(addr), .ba(ba), .ready(ready)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
  parameter int TIM_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             mobile_en,
  input logic [TIM_W-1:0] cfg_trp,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [1:0]       ba,
  input logic             ready,
  input logic             ev_pre,
  input logic             ev_emr
);
  localparam int GAP_W = TIM_W + 1;

  logic [3:0]       pins;
  logic             is_idle, is_ref, is_load;
  logic             pre_seen, ref_seen;
  logic [GAP_W-1:0] gap;

  assign pins    = {cs_n, ras_n, cas_n, we_n};
  assign is_idle = (pins == 4'b0111);
  assign is_ref  = (pins == 4'b0001);
  assign is_load = (pins == 4'b0000);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_seen <= 1'b0;
      ref_seen <= 1'b0;
      gap      <= '0;
    end else begin
      if (ev_pre) pre_seen <= 1'b1;
      if (is_ref) ref_seen <= 1'b1;
      if (!is_idle)       gap <= '0;
      else if (gap != '1) gap <= gap + 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!ready && !cke));

  // R3
  cke_low_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> is_idle);

  // R4
  pre_pins_chk: assert property (@(posedge clk) disable iff (rst)
    ev_pre |-> (cke && pins == 4'b0010));

  // R2
  pre_first_chk: assert property (@(posedge clk) disable iff (rst)
    (is_ref || is_load) |-> pre_seen);

  // R5
  trp_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (is_ref && !ref_seen) |-> (gap == {1'b0, cfg_trp}));

  // R8
  emr_mobile_chk: assert property (@(posedge clk) disable iff (rst)
    ev_emr |-> (mobile_en && is_load && ba == 2'b10));

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (cke && is_idle));
endmodule

bind sdram_boot_seq sdram_boot_chk #(.TIM_W(TIM_W)) chk_i (
  .clk(clk), .rst(rst), .mobile_en(mobile_en), .cfg_trp(cfg_trp),
  .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .ready(ready), .ev_pre(ev_pre), .ev_emr(ev_emr)
);

// File: tb/sdram_boot_seq_tb.sv
module sdram_boot_seq_tb_top;
  localparam int ADDR_W = 13;
  localparam int CNT_W  = 16;
  localparam int TIM_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mobile_en = 1'b0;
  logic [CNT_W-1:0]  cfg_init_wait = '0;
  logic [TIM_W-1:0]  cfg_trp = '0, cfg_trfc = '0, cfg_tmrd = '0;
  logic [ADDR_W-1:0] cfg_mode = '0, cfg_ext_mode = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [ADDR_W-1:0] addr;
  logic [1:0] ba;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;  // 50 MHz

  sdram_boot_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .TIM_W(TIM_W)) dut_i (
    .clk(clk), .rst(rst), .mobile_en(mobile_en),
    .cfg_init_wait(cfg_init_wait), .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc),
    .cfg_tmrd(cfg_tmrd), .cfg_mode(cfg_mode), .cfg_ext_mode(cfg_ext_mode),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .ready(ready)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Timeline positions, in samples after reset release (sample 0 = release).
  int p_pre, p_r1, p_r2, p_m, p_e, p_rdy, e_w;
  logic e_mob;

  function automatic void plan(input logic mob, input int w, input int trp,
                               input int trfc, input int tmrd);
    e_mob = mob;
    e_w   = w;
    p_pre = w + 2;
    p_r1  = p_pre + trp + 1;
    p_r2  = p_r1 + trfc + 1;
    p_m   = p_r2 + trfc + 1;
    p_e   = mob ? p_m + tmrd + 1 : -1;
    p_rdy = (mob ? p_e : p_m) + tmrd + 1;
  endfunction

  // {cke, cs_n, ras_n, cas_n, we_n, ba, addr, ready}
  function automatic logic [20:0] expect_at(input int k);
    logic [3:0] c = 4'b0111;
    logic [12:0] a = '0;
    logic [1:0] b = '0;
    logic ck = (k > e_w);
    logic rd = (k >= p_rdy);
    if (k == p_pre)      begin c = 4'b0010; a = 13'h0400; end
    else if (k == p_r1 || k == p_r2) c = 4'b0001;
    else if (k == p_m)   begin c = 4'b0000; a = cfg_mode; end
    else if (k == p_e)   begin c = 4'b0000; a = cfg_ext_mode; b = 2'b10; end
    return {ck, c, b, a, rd};
  endfunction

  function automatic string req_at(input int k, input string first_tag);
    if (k == 0)               return first_tag;
    if (k <= e_w + 1)         return "R2";
    if (k == p_pre)           return "R4";
    if (k < p_r1)             return "R5";
    if (k == p_r1 || k == p_r2 || k < p_m) return "R6";
    if (k == p_m)             return "R7";
    if (k == p_e)             return "R8";
    if (k >= p_rdy)           return "R9";
    return "R3";
  endfunction

  task automatic run(input logic mob, input int w, input int trp, input int trfc,
                     input int tmrd, input string first_tag, input int stop_at);
    logic [20:0] got, exp;
    string rq;
    @(negedge clk);
    rst = 1'b1;
    mobile_en = mob;
    cfg_init_wait = CNT_W'(w);
    cfg_trp  = TIM_W'(trp);
    cfg_trfc = TIM_W'(trfc);
    cfg_tmrd = TIM_W'(tmrd);
    cfg_mode = ADDR_W'($urandom);
    cfg_ext_mode = ADDR_W'($urandom);
    plan(mob, w, trp, trfc, tmrd);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k <= p_rdy + 4; k++) begin
      if (k > 0) @(negedge clk);
      if (stop_at >= 0 && k == stop_at) return;  // abandoned mid-sequence
      got = {cke, cs_n, ras_n, cas_n, we_n, ba, addr, ready};
      exp = expect_at(k);
      rq  = req_at(k, first_tag);
      if (trp == 0 && trfc == 0 && tmrd == 0 && k >= p_pre && k < p_rdy) rq = "R10";
      checks = checks + 1;
      if (got !== exp) begin
        errors = errors + 1;
        $display("FAIL %s sample %0d mob=%0b: actual=%h expected=%h", rq, k, mob, got, exp);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    // Directed corners
    run(1'b0, 5, 2, 3, 2, "R1", -1);         // ordinary sequence (R8: no ext load)
    run(1'b1, 5, 2, 3, 2, "R1", -1);         // mobile sequence (R8)
    run(1'b0, 0, 0, 0, 0, "R1", -1);         // R10 all zero, ordinary
    run(1'b1, 0, 0, 0, 0, "R1", -1);         // R10 all zero, mobile
    run(1'b1, 300, 7, 9, 3, "R1", -1);       // longer power-on wait (R2)
    run(1'b1, 8, 4, 4, 4, "R1", 14);         // interrupted mid-sequence
    run(1'b1, 8, 4, 4, 4, "R11", -1);        // R11 restart after reset
    run(1'b0, 6, 1, 5, 1, "R1", 3);          // interrupted during power-on wait
    run(1'b0, 6, 1, 5, 1, "R11", -1);        // R11
    // Constrained random
    for (int i = 0; i < 24; i++) begin
      run(1'($urandom_range(0, 1)), int'($urandom_range(0, 20)),
          int'($urandom_range(0, 6)), int'($urandom_range(0, 8)),
          int'($urandom_range(0, 4)), "R1", -1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule